// File: doc/BRIEF.md
# Boosted Cascade Stage Controller

This block steps one image subwindow through a boosted classifier cascade. Each stage holds a fixed number of weak classifiers. Every classifier returns a signed leaf value, and the block adds the leaf values of one stage into a stage sum. When the stage is complete, the block compares the sum against that stage's threshold. A window whose sum falls below the threshold of any stage is rejected on the spot, and no later stage is started. A window that clears every stage is reported as a face candidate.

The early stages are small and are reached by almost every window, so they are served by a bank of parallel evaluators. The block sends one request and receives every leaf of the stage in a single response. The later stages are reached by few windows. For those stages the block feeds a single pipelined evaluator one flat classifier index per cycle and accepts the leaves when they come back, whatever the latency.

The per-classifier arithmetic, the window normalization, the parameter memories and the threshold table are outside the block. The block presents the current stage number, and the threshold for that stage is returned on an input in the same cycle.

Top module: `casc_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no window started, `busy`, `par_req`, `cls_valid` and `det_valid` are all 0.
- R2: Each of stages 0, 1 and 2 is evaluated by a single one-cycle `par_req` pulse, with `stage_idx` naming the stage. When `par_ack` arrives, the stage sum is the sum of lanes 0 to count-1 of `par_leaves`, where lane l occupies bits [16*l+15:16*l]. Lanes at or above the stage's classifier count have no effect on the sum.
- R3: Stages 3 and later issue one classifier per cycle on `cls_valid` in consecutive cycles. `cls_idx` starts at the sum of the classifier counts of all earlier stages and increases by one per cycle. Per stage, the counts are 9, 16, 27, 32, 52, 53, 62, 72, 83, 91, 99, 115, 127, 135, 136, 137, 159, 155, 169, 196, 197, 181, 199, 211 and 200 (2913 in total).
- R4: The stage sum is cleared at the start of every stage and holds only the leaf values returned for that stage.
- R5: For a pipelined stage, the threshold comparison waits until as many `leaf_valid` results have been accepted as classifiers were issued. The leaf latency may be anywhere from 1 to 4 cycles.
- R6: If the stage sum is below `stage_thr` (signed compare), the block raises `det_valid` with `det_face`=0 and `det_stage` set to that stage. It issues no request or classifier for any later stage.
- R7: A sum equal to the threshold passes. When all 25 stages pass, the block raises `det_valid` with `det_face`=1 and `det_stage`=24.
- R8: `det_valid` lasts exactly one cycle per started window. `det_x` and `det_y` carry the coordinates captured on the accepted `win_start`.
- R9: A `win_start` while `busy` is 1 is ignored. It neither changes the reported coordinates nor produces an extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_start | input | 1 | Start evaluating a window (taken only when idle) |
| win_x | input | 10 | Window column |
| win_y | input | 9 | Window row |
| busy | output | 1 | A window is being evaluated |
| stage_idx | output | 5 | Stage currently evaluated, used for threshold and parallel lookup |
| stage_thr | input | 24 | Signed threshold for `stage_idx` |
| par_req | output | 1 | One-cycle request to the parallel evaluators |
| par_ack | input | 1 | Parallel leaves are valid |
| par_leaves | input | 432 | 27 signed 16-bit leaf lanes |
| cls_valid | output | 1 | A classifier index is issued to the pipelined evaluator |
| cls_idx | output | 12 | Flat classifier index |
| leaf_valid | input | 1 | A pipelined leaf returns |
| leaf_val | input | 16 | Signed leaf value |
| det_valid | output | 1 | One-cycle verdict pulse |
| det_face | output | 1 | 1 = all stages passed |
| det_x | output | 10 | Column of the judged window |
| det_y | output | 9 | Row of the judged window |
| det_stage | output | 5 | Failing stage, or 24 on a pass |

## Verification
In a pipelined stage, issuing a new classifier and accepting an earlier classifier's leaf usually happen in the same cycle. With a one-cycle evaluator latency they coincide on every cycle but the first and the last. The bench runs windows at latencies 1 through 4. It places thresholds exactly at the expected stage sums, or one above them, so that a single lost or doubled leaf, or a comparison made before the drain completes, flips the verdict or moves the reported failing stage. The bench also checks the issued index sequence and the number of classifiers issued per window against its own count table.

// File: rtl/cascade_pkg.sv
package cascade_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREQ,
    ST_PWAIT,
    ST_SER,
    ST_DRAIN,
    ST_CHECK
  } casc_state_t;

  localparam int DEF_STAGES = 25;

  localparam int unsigned DEF_CNT [DEF_STAGES] = '{
    9, 16, 27, 32, 52, 53, 62, 72, 83, 91, 99, 115, 127,
    135, 136, 137, 159, 155, 169, 196, 197, 181, 199, 211, 200
  };

endpackage

// File: rtl/casc_stage_rom.sv
module casc_stage_rom #(
  parameter int          NUM_STAGES = 25,
  parameter int          CNT_W      = 8,
  parameter int          IDX_W      = 12,
  parameter int          SW         = 5,
  parameter int unsigned CNT [NUM_STAGES] = cascade_pkg::DEF_CNT
) (
  input  logic [SW-1:0]    stage,
  output logic [CNT_W-1:0] cnt,
  output logic [IDX_W-1:0] base
);

  function automatic int unsigned base_of(input int g);
    int unsigned s;
    s = 0;
    for (int i = 0; i < g; i++) s += CNT[i];
    return s;
  endfunction

  logic [CNT_W-1:0] cnt_tab  [NUM_STAGES];
  logic [IDX_W-1:0] base_tab [NUM_STAGES];

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_tab
    localparam int unsigned B = base_of(g);
    localparam int unsigned C = CNT[g];
    assign cnt_tab[g]  = C[CNT_W-1:0];
    assign base_tab[g] = B[IDX_W-1:0];
  end

  assign cnt  = cnt_tab[stage];
  assign base = base_tab[stage];

endmodule

// File: rtl/casc_lane_sum.sv
module casc_lane_sum #(
  parameter int LANES  = 27,
  parameter int LEAF_W = 16,
  parameter int ACC_W  = 24,
  parameter int CNT_W  = 8
) (
  input  logic [LANES*LEAF_W-1:0] leaves,
  input  logic [CNT_W-1:0]        cnt,
  output logic signed [ACC_W-1:0] total
);

  logic signed [ACC_W-1:0] term [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LEAF_W-1:0] lf;
    assign lf      = leaves[g*LEAF_W +: LEAF_W];
    assign term[g] = (cnt > CNT_W'(g)) ? {{(ACC_W-LEAF_W){lf[LEAF_W-1]}}, lf} : '0;
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) total = total + term[i];
  end

endmodule

// File: rtl/casc_ser_track.sv
module casc_ser_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             issue,
  input  logic             accept,
  output logic [CNT_W-1:0] issued,
  output logic [CNT_W-1:0] rcvd
);

  logic [CNT_W-1:0] issued_d, rcvd_d;
  logic             iss_en, rcv_en;

  always_comb begin
    iss_en   = clr | issue;
    rcv_en   = clr | accept;
    issued_d = clr ? '0 : issued + CNT_W'(1);
    rcvd_d   = clr ? '0 : rcvd + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued <= '0;
      rcvd   <= '0;
    end else begin
      if (iss_en) issued <= issued_d;
      if (rcv_en) rcvd   <= rcvd_d;
    end
  end

endmodule

// File: rtl/casc_ctrl.sv
module casc_ctrl
  import cascade_pkg::*;
#(
  parameter int          NUM_STAGES = 25,
  parameter int          PAR_STAGES = 3,
  parameter int          PAR_LANES  = 27,
  parameter int          LEAF_W     = 16,
  parameter int          ACC_W      = 24,
  parameter int          CNT_W      = 8,
  parameter int          IDX_W      = 12,
  parameter int          X_W        = 10,
  parameter int          Y_W        = 9,
  parameter int unsigned CNT [NUM_STAGES] = cascade_pkg::DEF_CNT,
  localparam int         SW = $clog2(NUM_STAGES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_start,
  input  logic [X_W-1:0]          win_x,
  input  logic [Y_W-1:0]          win_y,
  output logic                    busy,
  output logic [SW-1:0]           stage_idx,
  input  logic [ACC_W-1:0]        stage_thr,
  output logic                    par_req,
  input  logic                    par_ack,
  input  logic [PAR_LANES*LEAF_W-1:0] par_leaves,
  output logic                    cls_valid,
  output logic [IDX_W-1:0]        cls_idx,
  input  logic                    leaf_valid,
  input  logic [LEAF_W-1:0]       leaf_val,
  output logic                    det_valid,
  output logic                    det_face,
  output logic [X_W-1:0]          det_x,
  output logic [Y_W-1:0]          det_y,
  output logic [SW-1:0]           det_stage
);

  localparam logic [SW-1:0] LAST_STG = SW'(NUM_STAGES - 1);
  localparam logic [SW-1:0] PAR_LIM  = SW'(PAR_STAGES);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  casc_state_t             st_q, st_d;
  logic [SW-1:0]           stg_q, stg_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic [X_W-1:0]          x_q;
  logic [Y_W-1:0]          y_q;
  logic                    dv_q, dv_d, df_q, df_d;
  logic [SW-1:0]           ds_q, ds_d;
  logic                    xy_en, acc_en, stg_en, res_en, stage_clr;

  logic [CNT_W-1:0]        cur_cnt, issued, rcvd;
  logic [IDX_W-1:0]        cur_base;
  logic signed [ACC_W-1:0] lane_total, leaf_ext, thr_s;
  logic                    ser_accept, stage_pass, last_issue, next_par;

  casc_stage_rom #(
    .NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W), .IDX_W(IDX_W), .SW(SW), .CNT(CNT)
  ) u_rom (
    .stage(stg_q), .cnt(cur_cnt), .base(cur_base)
  );

  casc_lane_sum #(
    .LANES(PAR_LANES), .LEAF_W(LEAF_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
  ) u_lanes (
    .leaves(par_leaves), .cnt(cur_cnt), .total(lane_total)
  );

  casc_ser_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_i), .clr(stage_clr), .issue(cls_valid),
    .accept(ser_accept), .issued(issued), .rcvd(rcvd)
  );

  assign leaf_ext   = {{(ACC_W-LEAF_W){leaf_val[LEAF_W-1]}}, leaf_val};
  assign thr_s      = stage_thr;
  assign ser_accept = leaf_valid && (st_q == ST_SER || st_q == ST_DRAIN);
  assign stage_pass = (acc_q >= thr_s);
  assign last_issue = (issued + CNT_W'(1) == cur_cnt);
  assign next_par   = (PAR_LIM > stg_q + SW'(1));

  // next-state process
  always_comb begin
    st_d      = st_q;
    stg_d     = stg_q;
    acc_d     = acc_q;
    dv_d      = 1'b0;
    df_d      = df_q;
    ds_d      = ds_q;
    xy_en     = 1'b0;
    stage_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (win_start) begin
          xy_en     = 1'b1;
          stg_d     = '0;
          acc_d     = '0;
          stage_clr = 1'b1;
          st_d      = (PAR_STAGES > 0) ? ST_PREQ : ST_SER;
        end
      end
      ST_PREQ:  st_d = ST_PWAIT;
      ST_PWAIT: begin
        if (par_ack) begin
          acc_d = lane_total;
          st_d  = ST_CHECK;
        end
      end
      ST_SER: begin
        if (ser_accept) acc_d = acc_q + leaf_ext;
        if (last_issue) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (ser_accept) acc_d = acc_q + leaf_ext;
        if (rcvd == cur_cnt) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (!stage_pass || stg_q == LAST_STG) begin
          dv_d = 1'b1;
          df_d = stage_pass;
          ds_d = stg_q;
          st_d = ST_IDLE;
        end else begin
          stg_d     = stg_q + SW'(1);
          acc_d     = '0;
          stage_clr = 1'b1;
          st_d      = next_par ? ST_PREQ : ST_SER;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    acc_en = (acc_d != acc_q);
    stg_en = (stg_d != stg_q);
    res_en = dv_d;
  end

  // register process
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= ST_IDLE;
      stg_q <= '0;
      acc_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
      dv_q  <= 1'b0;
      df_q  <= 1'b0;
      ds_q  <= '0;
    end else begin
      st_q <= st_d;
      dv_q <= dv_d;
      if (stg_en) stg_q <= stg_d;
      if (acc_en) acc_q <= acc_d;
      if (xy_en) begin
        x_q <= win_x;
        y_q <= win_y;
      end
      if (res_en) begin
        df_q <= df_d;
        ds_q <= ds_d;
      end
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign stage_idx = stg_q;
  assign par_req   = (st_q == ST_PREQ);
  assign cls_valid = (st_q == ST_SER);
  assign cls_idx   = cur_base + IDX_W'(issued);
  assign det_valid = dv_q;
  assign det_face  = df_q;
  assign det_stage = ds_q;
  assign det_x     = x_q;
  assign det_y     = y_q;

endmodule

// File: rtl/casc_chk.sv
module casc_chk #(
  parameter int NUM_STAGES = 25,
  parameter int PAR_STAGES = 3,
  parameter int IDX_W      = 12,
  parameter int SW         = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             par_req,
  input logic             cls_valid,
  input logic [IDX_W-1:0] cls_idx,
  input logic [SW-1:0]    stage_idx,
  input logic             det_valid,
  input logic             det_face,
  input logic [SW-1:0]    det_stage
);

  AST_PAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    par_req |=> !par_req); // R2

  AST_PAR_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    par_req |-> (stage_idx < SW'(PAR_STAGES))); // R2

  AST_SER_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> (stage_idx >= SW'(PAR_STAGES))); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && $past(cls_valid)) |-> (cls_idx == $past(cls_idx) + IDX_W'(1))); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cls_valid && !par_req)); // R6

  AST_FACE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_face) |-> (det_stage == SW'(NUM_STAGES - 1))); // R7

  AST_DET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |=> !det_valid); // R8

endmodule

bind casc_ctrl casc_chk #(
  .NUM_STAGES(NUM_STAGES), .PAR_STAGES(PAR_STAGES), .IDX_W(IDX_W), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .par_req(par_req),
  .cls_valid(cls_valid), .cls_idx(cls_idx), .stage_idx(stage_idx),
  .det_valid(det_valid), .det_face(det_face), .det_stage(det_stage)
);

// File: tb/sim_casc_ctrl.sv
module sim_casc_ctrl;

  localparam int NS = 25, LANES = 27, LW = 16, AW = 24;
  localparam int CB [NS] = '{9, 16, 27, 32, 52, 53, 62, 72, 83, 91, 99, 115, 127,
                             135, 136, 137, 159, 155, 169, 196, 197, 181, 199, 211, 200};

  logic clk = 1'b0, rst_n = 1'b0, win_start = 1'b0;
  logic [9:0] win_x = '0;
  logic [8:0] win_y = '0;
  logic busy, par_req, cls_valid, det_valid, det_face;
  logic [4:0] stage_idx, det_stage;
  logic [AW-1:0] stage_thr;
  logic par_ack = 1'b0;
  logic [LANES*LW-1:0] par_leaves = '0;
  logic [11:0] cls_idx;
  logic leaf_valid;
  logic [LW-1:0] leaf_val;
  logic [9:0] det_x;
  logic [8:0] det_y;

  casc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_x(win_x), .win_y(win_y),
    .busy(busy), .stage_idx(stage_idx), .stage_thr(stage_thr), .par_req(par_req),
    .par_ack(par_ack), .par_leaves(par_leaves), .cls_valid(cls_valid), .cls_idx(cls_idx),
    .leaf_valid(leaf_valid), .leaf_val(leaf_val), .det_valid(det_valid),
    .det_face(det_face), .det_x(det_x), .det_y(det_y), .det_stage(det_stage)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int thr_tab [NS];
  int seed_cur = 0, lat = 1;
  int n_par = 0, n_ser = 0, idx_err = 0, got_n = 0;
  int got_face = 0, got_stage = 0, got_x = 0, got_y = 0;
  logic [3:0] vpipe = '0;
  int ipipe [4] = '{0, 0, 0, 0};
  bit prev_cv = 1'b0;
  int last_idx = 0;
  bit p_pend = 1'b0;
  int p_cnt = 0, p_stage = 0;

  function automatic int base_b(int s);
    int b = 0;
    for (int i = 0; i < s; i++) b += CB[i];
    return b;
  endfunction

  function automatic int leaf_of(int sd, int idx);
    return (((sd * 131 + idx * 29) ^ (idx * 7)) & 63) - 30;
  endfunction

  always_comb stage_thr = AW'(thr_tab[stage_idx]);
  always_comb begin
    leaf_valid = vpipe[lat-1];
    leaf_val   = LW'(leaf_of(seed_cur, ipipe[lat-1]));
  end

  // stand-in evaluators, updated with nonblocking assignments at the edge
  always @(posedge clk) begin
    vpipe <= {vpipe[2:0], cls_valid};
    ipipe[3] <= ipipe[2];
    ipipe[2] <= ipipe[1];
    ipipe[1] <= ipipe[0];
    ipipe[0] <= int'(cls_idx);
    if (cls_valid) begin
      int e;
      n_ser++;
      e = prev_cv ? last_idx + 1 : base_b(int'(stage_idx));
      if (int'(cls_idx) != e) idx_err++;
      last_idx = int'(cls_idx);
    end
    prev_cv = cls_valid;
    par_ack <= 1'b0;
    if (p_pend) begin
      if (p_cnt <= 1) begin
        logic [LANES*LW-1:0] lv;
        for (int l = 0; l < LANES; l++)
          lv[l*LW +: LW] = (l < CB[p_stage]) ? LW'(leaf_of(seed_cur, base_b(p_stage) + l))
                                             : LW'($urandom);
        par_leaves <= lv;
        par_ack    <= 1'b1;
        p_pend = 1'b0;
      end else p_cnt--;
    end
    if (par_req) begin
      n_par++;
      p_pend  = 1'b1;
      p_cnt   = lat;
      p_stage = int'(stage_idx);
    end
  end

  always @(negedge clk) begin
    if (rst_n && det_valid) begin
      got_n++;
      got_face  = int'(det_face);
      got_stage = int'(det_stage);
      got_x     = int'(det_x);
      got_y     = int'(det_y);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // F = failing stage (NS means every stage passes)
  task automatic run_window(int x, int y, int sd, int f, int lt, bit slack, bit poke);
    int exp_par, exp_ser;
    for (int s = 0; s < NS; s++) begin
      int es = 0;
      for (int k = 0; k < CB[s]; k++) es += leaf_of(sd, base_b(s) + k);
      if (s == f) thr_tab[s] = es + 1;
      else thr_tab[s] = slack ? es - int'($urandom % 5) : es;
    end
    seed_cur = sd; lat = lt;
    n_par = 0; n_ser = 0; idx_err = 0; got_n = 0;
    exp_par = (f < NS) ? ((f + 1 < 3) ? f + 1 : 3) : 3;
    exp_ser = 0;
    for (int s = 3; s < NS && s <= f; s++) exp_ser += CB[s];
    @(negedge clk);
    win_x = 10'(x); win_y = 9'(y); win_start = 1'b1;
    @(negedge clk);
    win_start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      win_x = 10'(x ^ 5); win_y = 9'(y ^ 3); win_start = 1'b1;
      @(negedge clk);
      win_start = 1'b0;
    end
    for (int c = 0; c < 20000 && got_n == 0; c++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(got_n == 1, "R8 one verdict pulse", got_n, 1);
    chk(got_face == int'(f >= NS), (f >= NS) ? "R7 face flag" : "R6 face flag",
        got_face, int'(f >= NS));
    chk(got_stage == ((f >= NS) ? NS - 1 : f), (f >= NS) ? "R7 stage" : "R6 failing stage",
        got_stage, (f >= NS) ? NS - 1 : f);
    chk(got_x == x && got_y == y, poke ? "R9 coords kept" : "R8 coords",
        got_x * 1000 + got_y, x * 1000 + y);
    chk(n_par == exp_par, "R2 parallel requests", n_par, exp_par);
    chk(n_ser == exp_ser, "R6 serial issues", n_ser, exp_ser);
    chk(idx_err == 0, "R3 index order", idx_err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < NS; s++) thr_tab[s] = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !par_req && !cls_valid && !det_valid, "R1 in reset",
        int'({busy, par_req, cls_valid, det_valid}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !par_req && !cls_valid && !det_valid, "R1 after reset",
        int'({busy, par_req, cls_valid, det_valid}), 0);
    // directed corners
    run_window(12, 34, 1, 0, 1, 1'b0, 1'b0);    // R2 R6 first stage fails
    run_window(99, 7, 2, 2, 3, 1'b0, 1'b0);     // R2 R4 last parallel stage
    run_window(5, 200, 3, 3, 1, 1'b0, 1'b1);    // R3 R5 R9 first serial stage
    run_window(640 % 1024, 100, 4, NS, 1, 1'b0, 1'b0); // R7 equality passes, latency 1
    run_window(321, 240, 5, NS - 1, 4, 1'b0, 1'b0);    // R5 R6 last stage fails
    run_window(77, 55, 6, NS, 4, 1'b1, 1'b1);          // R7 R9 pass with slack
    // random windows
    for (int w = 0; w < 16; w++) begin
      int f = int'($urandom % 20);
      if (w % 5 == 4) f = NS;
      run_window(int'($urandom % 1024), int'($urandom % 512), 10 + w, f,
                 1 + int'($urandom % 4), 1'($urandom), (f >= 3) ? 1'($urandom) : 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule